// File: doc/BRIEF.md
# Buffered PWM Timer Channel Pair

This block is a 16-bit timer that produces one pulse-width-modulated pin. A free-running counter counts from zero up to a programmable period limit and then wraps to zero. Each wrap begins a new PWM period. The pin is driven high at the start of the period. It falls when the counter reaches the compare value in force, so the high time is the compare value in clock cycles. Two sticky event flags record the wrap and the compare match. Software clears each flag by writing a 1 to its bit.

Software changes the duty cycle through an 8-bit write bus. Two channel register pairs are provided, and each pair is written as a high byte followed by a low byte. A high byte on its own only waits in a holding latch. The low byte joins it to form a complete 16-bit value. That value becomes the pending compare value, and it is selected from whichever pair completed most recently. The pending value moves into the active compare register only when the counter wraps. A write therefore cannot change the compare value partway through a period, even when it lands on the same clock as a wrap or a compare match. This prevents both a half-updated value and a period stuck fully low or fully high.

Top module: `bpwm_pair`

## Requirements
- R1: The counter steps by one each clock and goes to 0 on the clock after it holds a value at or above the period limit. The period limit is written as a high byte at address 0, which is held, and then a low byte at address 1, which commits the 16-bit limit. After reset the limit is all ones.
- R2: The overflow flag (`ovf_flag`) is set on every wrap and stays set until software writes address 6 with data bit 0 = 1. If that clear lands on the same clock as a wrap, the flag stays set.
- R3: The compare flag (`cmp_flag`) is set on the clock where the counter reaches the active compare value. It is cleared by a write to address 6 with data bit 1 = 1. If that clear lands on the same clock as a match, the flag stays set.
- R4: `pwm_out` is high while the counter is below the active compare value. Over one period of limit+1 clocks, the output is high for min(compare, limit+1) clocks. A compare value of 0 gives a constant low output, and a compare value above the limit gives a constant high output.
- R5: Pair A is written at addresses 2 (high byte) and 3 (low byte). Pair B is written at addresses 4 (high byte) and 5 (low byte). A high-byte write on its own has no effect on the output. The new value takes effect only after the matching low byte is written.
- R6: The compare value in force comes from whichever pair most recently completed a low-byte write.
- R7: A completed value is moved into the active compare register only at a wrap. If the low-byte write lands on the same clock as a wrap, the output follows the old value for the period that starts on that clock and the new value from the following period on.
- R8: A low-byte write that coincides with a wrap or with a compare match never produces a period with 0 % or 100 % high time, provided both the old and the new compare values lie strictly between 0 and limit+1.
- R9: While `rst` is high, on each clock the counter, both channel pairs, their holding bytes, the active compare value and both flags are cleared, and `pwm_out` is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0..6, see R1, R2, R5) |
| wr_data | input | 8 | Write data byte |
| count | output | 16 | Current counter value |
| pwm_out | output | 1 | Buffered PWM pin |
| ovf_flag | output | 1 | Sticky overflow (wrap) flag |
| cmp_flag | output | 1 | Sticky compare-match flag |

## Verification
The duty function is tried with a table of period-limit and compare pairs. The table covers a value inside the period, a compare of zero, a compare equal to limit+1, a compare above the limit, a compare of one, and a compare equal to the limit, with both pairs used. These cases separate normal duty from the 0 % and 100 % clamps and from off-by-one errors at each end of the period. Directed tests place a low-byte write exactly on the wrap clock and exactly on the compare-match clock. Each period is then counted from its start, which shows whether the new value took effect one period late, took effect early, or produced a glitch. Separate tests write only a high byte, alternate between the two pairs, and clear each flag both on a quiet clock and on a colliding clock. These show the holding latch, the selection of the most recent pair, and the priority of a flag set over a clear.

// File: rtl/bpwm_pkg.sv
package bpwm_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;
    localparam int NPAIR  = 2;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // register addresses
    localparam addr_t AD_MOD_HI = 3'd0;
    localparam addr_t AD_MOD_LO = 3'd1;
    localparam addr_t AD_PAIR0  = 3'd2;   // pair p: high at AD_PAIR0+2p, low at +1
    localparam addr_t AD_FLAGS  = 3'd6;

    typedef enum logic {PAIR_A = 1'b0, PAIR_B = 1'b1} pair_e;

    typedef struct packed {
        logic  en;
        addr_t addr;
        byte_t data;
    } bus_wr_t;

    typedef struct packed {
        logic  valid;
        pair_e sel;
    } pend_t;

    typedef struct packed {
        logic ovf;
        logic cmp;
    } evt_t;

    // sticky flag update: a new event outranks a clear on the same clock
    function automatic logic flag_next(logic cur, logic set, logic clr);
        return set | (cur & ~clr);
    endfunction
endpackage

// File: rtl/bpwm_counter.sv
module bpwm_counter
    import bpwm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cnt_t limit,
    output cnt_t cnt_q,
    output cnt_t cnt_next,
    output logic wrap
);
    // wrap at or beyond the limit so a lowered limit never strands the count
    assign wrap     = (cnt_q >= limit);
    assign cnt_next = wrap ? '0 : cnt_q + cnt_t'(1);

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_next;
    end
endmodule

// File: rtl/bpwm_regs.sv
module bpwm_regs
    import bpwm_pkg::*;
#(
    parameter cnt_t MOD_INIT = '1
) (
    input  logic    clk,
    input  logic    rst,
    input  bus_wr_t wr,
    input  logic    wrap,
    output cnt_t    mod_q,
    output cnt_t    active_q,
    output cnt_t    active_next
);
    byte_t              mod_hi_q;
    byte_t              hi_hold [NPAIR];
    cnt_t               pair_val[NPAIR];
    logic [NPAIR-1:0]   lo_hit;
    pend_t              pend_q;
    cnt_t               staged;

    // period limit: high byte held, low byte commits the full value
    always_ff @(posedge clk) begin
        if (rst) begin
            mod_hi_q <= '0;
            mod_q    <= MOD_INIT;
        end else if (wr.en) begin
            if (wr.addr == AD_MOD_HI) mod_hi_q <= wr.data;
            if (wr.addr == AD_MOD_LO) mod_q    <= {mod_hi_q, wr.data};
        end
    end

    // one holding byte and one 16-bit value per channel pair
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        localparam addr_t HI_AD = addr_t'(AD_PAIR0 + addr_t'(2 * p));
        localparam addr_t LO_AD = addr_t'(HI_AD + addr_t'(1));

        assign lo_hit[p] = wr.en && (wr.addr == LO_AD);

        always_ff @(posedge clk) begin
            if (rst) begin
                hi_hold[p]  <= '0;
                pair_val[p] <= '0;
            end else begin
                if (wr.en && wr.addr == HI_AD) hi_hold[p]  <= wr.data;
                if (lo_hit[p])                 pair_val[p] <= {hi_hold[p], wr.data};
            end
        end
    end

    assign staged = (pend_q.sel == PAIR_B) ? pair_val[1] : pair_val[0];

    // transfer uses the state before this clock; a colliding write stays pending
    assign active_next = (wrap && pend_q.valid) ? staged : active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= '{valid: 1'b0, sel: PAIR_A};
            active_q <= '0;
        end else begin
            active_q <= active_next;
            if (wrap) pend_q.valid <= 1'b0;
            if (|lo_hit) begin
                pend_q.valid <= 1'b1;
                pend_q.sel   <= lo_hit[1] ? PAIR_B : PAIR_A;
            end
        end
    end
endmodule

// File: rtl/bpwm_out.sv
module bpwm_out
    import bpwm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cnt_t cnt_next,
    input  cnt_t cmp_next,
    input  logic wrap,
    input  logic clr_ovf,
    input  logic clr_cmp,
    output logic pwm_out,
    output logic ovf_flag,
    output logic cmp_flag
);
    evt_t flags_q;
    evt_t hit;

    assign hit.ovf = wrap;
    assign hit.cmp = (cnt_next == cmp_next);

    // level follows the values that will hold after this edge,
    // so a period can only start high (cmp != 0) and fall once
    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_out <= 1'b0;
            flags_q <= '0;
        end else begin
            pwm_out     <= (cnt_next < cmp_next);
            flags_q.ovf <= flag_next(flags_q.ovf, hit.ovf, clr_ovf);
            flags_q.cmp <= flag_next(flags_q.cmp, hit.cmp, clr_cmp);
        end
    end

    assign ovf_flag = flags_q.ovf;
    assign cmp_flag = flags_q.cmp;
endmodule

// File: rtl/bpwm_pair.sv
module bpwm_pair
    import bpwm_pkg::*;
#(
    parameter cnt_t MOD_INIT = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [CNT_W-1:0]  count,
    output logic              pwm_out,
    output logic              ovf_flag,
    output logic              cmp_flag
);
    bus_wr_t wr;
    cnt_t    mod_q;
    cnt_t    active_q;
    cnt_t    active_next;
    cnt_t    cnt_next;
    logic    wrap;
    logic    clr_ovf;
    logic    clr_cmp;

    assign wr      = '{en: wr_en, addr: wr_addr, data: wr_data};
    assign clr_ovf = wr_en && (wr_addr == AD_FLAGS) && wr_data[0];
    assign clr_cmp = wr_en && (wr_addr == AD_FLAGS) && wr_data[1];

    bpwm_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .limit    (mod_q),
        .cnt_q    (count),
        .cnt_next (cnt_next),
        .wrap     (wrap)
    );

    bpwm_regs #(.MOD_INIT(MOD_INIT)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr          (wr),
        .wrap        (wrap),
        .mod_q       (mod_q),
        .active_q    (active_q),
        .active_next (active_next)
    );

    bpwm_out u_out (
        .clk      (clk),
        .rst      (rst),
        .cnt_next (cnt_next),
        .cmp_next (active_next),
        .wrap     (wrap),
        .clr_ovf  (clr_ovf),
        .clr_cmp  (clr_cmp),
        .pwm_out  (pwm_out),
        .ovf_flag (ovf_flag),
        .cmp_flag (cmp_flag)
    );
endmodule

// File: rtl/bpwm_checker.sv
module bpwm_checker
    import bpwm_pkg::*;
(
    input logic clk,
    input logic rst,
    input cnt_t count,
    input cnt_t modulo,
    input cnt_t active,
    input logic pwm_out,
    input logic ovf_flag,
    input logic cmp_flag
);
    // R1: wrap after reaching the limit
    p_wrap_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (count >= modulo) |=> (count == '0));

    // R1: single step below the limit
    p_step_one_r1: assert property (@(posedge clk) disable iff (rst)
        (count < modulo) |=> (count == $past(count) + cnt_t'(1)));

    // R2: every wrap leaves the overflow flag set
    p_ovf_set_r2: assert property (@(posedge clk) disable iff (rst)
        (count >= modulo) |=> ovf_flag);

    // R3: compare flag rises only when the count meets the active value
    p_cmp_rise_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(cmp_flag) |-> (count == active));

    // R4: pin high exactly while count is below the active compare
    p_level_r4: assert property (@(posedge clk) disable iff (rst)
        pwm_out == (count < active));

    // R7: active compare changes only at the start of a period
    p_xfer_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (active != $past(active)) |-> (count == '0));

    // R9: reset state
    p_reset_r9: assert property (@(posedge clk)
        rst |=> (count == '0 && !pwm_out && !ovf_flag && !cmp_flag && active == '0));
endmodule

bind bpwm_pair bpwm_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .count    (count),
    .modulo   (mod_q),
    .active   (active_q),
    .pwm_out  (pwm_out),
    .ovf_flag (ovf_flag),
    .cmp_flag (cmp_flag)
);

// File: tb/bpwm_pair_bench.sv
module bpwm_pair_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] count;
    logic        pwm_out, ovf_flag, cmp_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    bpwm_pair u_bpwm_pair (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .count(count), .pwm_out(pwm_out), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
    );

    always #4 clk = ~clk;   // 125 MHz

    typedef struct packed {
        logic [15:0] lim;
        logic [15:0] cmpv;
        logic        pair;
        logic [15:0] exp_hi;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{16'd9,  16'd3,  1'b0, 16'd3},   // inside period
        '{16'd9,  16'd0,  1'b1, 16'd0},   // 0 %
        '{16'd9,  16'd10, 1'b0, 16'd10},  // compare = limit+1 -> 100 %
        '{16'd9,  16'd12, 1'b1, 16'd10},  // above limit -> 100 %
        '{16'd4,  16'd1,  1'b0, 16'd1},   // single cycle
        '{16'd15, 16'd8,  1'b1, 16'd8},   // half
        '{16'd9,  16'd9,  1'b0, 16'd9}    // compare = limit
    };

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_now(logic [2:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        wr_now(a, d);
    endtask

    task automatic set_lim(logic [15:0] v);
        wr(3'd0, v[15:8]);
        wr(3'd1, v[7:0]);
    endtask

    task automatic set_pair(logic p, logic [15:0] v);
        wr(p ? 3'd4 : 3'd2, v[15:8]);
        wr(p ? 3'd5 : 3'd3, v[7:0]);
    endtask

    task automatic wait_count(logic [15:0] v);
        while (count != v) @(negedge clk);
    endtask

    // high cycles over any lim+1 consecutive clocks
    task automatic measure(int lim, output int hi);
        hi = 0;
        for (int i = 0; i <= lim; i++) begin
            @(negedge clk);
            hi += int'(pwm_out);
        end
    endtask

    // high cycles over one period, starting at count 0
    task automatic measure_aligned(int lim, output int hi);
        wait_count(16'd0);
        hi = 0;
        for (int i = 0; i <= lim; i++) begin
            hi += int'(pwm_out);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int hi, hi2, errs, mx, prev, bad;
        // R9: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 count", int'(count), 0);
        chk("R9 pwm_out", int'(pwm_out), 0);
        chk("R9 ovf_flag", int'(ovf_flag), 0);
        chk("R9 cmp_flag", int'(cmp_flag), 0);
        rst = 1'b0;

        // R4: duty table
        for (int v = 0; v < NVEC; v++) begin
            set_lim(VECS[v].lim);
            set_pair(VECS[v].pair, VECS[v].cmpv);
            repeat (2 * (int'(VECS[v].lim) + 1) + 6) @(negedge clk);
            measure(int'(VECS[v].lim), hi);
            chk($sformatf("R4 vector %0d high cycles", v), hi, int'(VECS[v].exp_hi));
        end

        // R1: counting and wrap with limit 9
        set_lim(16'd9);
        set_pair(1'b0, 16'd3);
        repeat (25) @(negedge clk);
        errs = 0; mx = 0; prev = int'(count);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (int'(count) != ((prev >= 9) ? 0 : prev + 1)) errs++;
            if (int'(count) > mx) mx = int'(count);
            prev = int'(count);
        end
        chk("R1 step/wrap errors", errs, 0);
        chk("R1 max count", mx, 9);

        // R2: overflow flag sticky, clear, set-over-clear
        chk("R2 ovf set", int'(ovf_flag), 1);
        wait_count(16'd3);
        wr_now(3'd6, 8'h01);
        chk("R2 ovf cleared", int'(ovf_flag), 0);
        wait_count(16'd9);
        wr_now(3'd6, 8'h01);
        chk("R2 ovf set wins over clear", int'(ovf_flag), 1);

        // R3: compare flag clear, set-over-clear (active = 3)
        wait_count(16'd5);
        wr_now(3'd6, 8'h02);
        chk("R3 cmp cleared", int'(cmp_flag), 0);
        wait_count(16'd2);
        wr_now(3'd6, 8'h02);
        chk("R3 cmp set wins over clear", int'(cmp_flag), 1);

        // R5: high byte alone is held
        wr(3'd2, 8'h01);
        repeat (35) @(negedge clk);
        measure(9, hi);
        chk("R5 high byte alone no effect", hi, 3);
        wr(3'd3, 8'h00);     // 0x0100 > limit -> full
        repeat (25) @(negedge clk);
        measure(9, hi);
        chk("R5 low byte completes value", hi, 10);

        // R6: most recently completed pair in force
        set_pair(1'b0, 16'd2);
        set_pair(1'b1, 16'd7);
        repeat (25) @(negedge clk);
        measure(9, hi);
        chk("R6 pair B latest", hi, 7);
        set_pair(1'b0, 16'd4);
        repeat (25) @(negedge clk);
        measure(9, hi);
        chk("R6 pair A latest", hi, 4);

        // R7/R8: low byte lands on the wrap clock (old 4, new 6)
        wr(3'd4, 8'h00);
        wait_count(16'd9);
        wr_now(3'd5, 8'd6);
        measure_aligned(9, hi);
        measure_aligned(9, hi2);
        chk("R7 period after colliding write keeps old", hi, 4);
        chk("R7 following period uses new", hi2, 6);
        bad = 0;
        if (hi == 0 || hi == 10) bad++;
        if (hi2 == 0 || hi2 == 10) bad++;
        chk("R8 no 0%/100% period at wrap collision", bad, 0);

        // R8: low byte lands on the compare-match clock (old 6, new 2)
        wr(3'd2, 8'h00);
        wait_count(16'd5);
        wr_now(3'd3, 8'd2);
        hi = 0;
        while (count != 16'd0) begin
            hi += int'(pwm_out);
            @(negedge clk);
        end
        chk("R8 no high tail after compare collision", hi, 0);
        measure_aligned(9, hi2);
        chk("R7 compare-collided value at next period", hi2, 2);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule